// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for Ethernet PHYs. A host reaches it through one 32-bit command/status word on a plain write-strobe and read-data bus. A single write with the go bit set starts one complete management frame on the serial clock and data pins. The data pin is split into output, output-enable and input, so a pad or a tri-state buffer can be placed outside the block.

The frame's start code and opcode are taken unchanged from fields of the command word. One command format therefore carries both Clause 22 frames and Clause 45 frames. A Clause 45 access takes two commands in turn. The first is an address frame that carries the device address in the register field and the 16-bit register address in the data field. The second performs the read or the write on that same device. Software polls the busy bit before and after each command. When a read finishes, the 16 bits returned by the PHY appear in the low half of the same word.

The serial clock is the system clock divided by a parameter. The master changes the data pin only on falling serial-clock edges and samples read data on rising edges.

Top module: `mdio_master`

## Requirements
- R1: A bus write with bit 31 set, accepted while idle, starts a frame, and bit 31 of the read word is 1 from the next clock cycle.
- R2: Each frame carries 64 bits, MSB first: 32 ones, then ST = command bits 17:16, OP = bits 19:18, PHY address = bits 24:20, register/device address = bits 29:25, two turnaround bits, then 16 data bits. ST 01 gives Clause 22 framing and ST 00 gives Clause 45 framing.
- R3: For OP values 0 (Clause 45 address) and 1 (write), the master drives the turnaround bits as 1 then 0 and drives command bits 15:0 as the data bits.
- R4: For OP values 2 (Clause 22 read) and 3 (Clause 45 read), the output enable is low for both turnaround bits and all 16 data bits. The master samples the data on rising serial-clock edges, and after busy clears those 16 bits read back in bits 15:0.
- R5: Busy clears on the clock edge of the final falling serial-clock edge, 128 x HALF_DIV clock cycles after the accepting edge. The serial clock is low whenever the block is idle.
- R6: A write that arrives while busy is ignored: the frame in progress is unchanged, no further frame follows, and bits 29:16 keep their values.
- R7: Every serial-clock half period lasts HALF_DIV clock cycles, and the data output changes only together with a falling serial-clock edge.
- R8: The data output enable is low whenever the block is idle.
- R9: After a frame, bits 29:16 read back the fields of the last accepted command, bit 30 reads 0, and for a write or address frame bits 15:0 read back the data that was written.
- R10: A write with bit 31 clear, made while idle, starts no frame and leaves the read word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the command word |
| reg_wdata_i | input | 32 | Command word to write |
| reg_rdata_o | output | 32 | Status/result word: busy, command fields, data |
| mdc_o | output | 1 | Management serial clock |
| mdio_o | output | 1 | Serial data output value |
| mdio_oe_o | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data input from the pin |

## Verification
A wrong bit counter or shift state shows up at once in the captured 64-bit line pattern. It also moves the busy-clear cycle away from 128 x HALF_DIV, and the bench counts that cycle exactly. A divider fault shows within one half period, as a serial-clock edge at the wrong cycle count. A wrong output-enable window or wrong sampling phase changes the read-back value, or the enable mask seen on the wire, in the same frame. An ignore path that leaks is caught by an extra frame, or by changed fields, seen right after the first frame ends.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_IDX     = 46;
  localparam int unsigned DATA_IDX   = 48;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    OP_ADDR45 = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ22 = 2'd2,
    OP_READ45 = 2'd3
  } mdio_op_e;

  typedef struct packed {
    logic       go;
    logic       rsvd;
    logic [4:0] regad;
    logic [4:0] phyad;
    logic [1:0] op;
    logic [1:0] st;
    logic [15:0] data;
  } mdio_cmd_t;

  function automatic logic op_is_read(logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  read_i,
  input  logic                  tick_i,
  input  logic                  mdio_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  mdc_o,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  output logic [15:0]           rd_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic                  busy_q, mdc_q, read_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [15:0]           rd_q;
  logic                  in_data, in_released, last_fall;

  assign in_data     = idx_q >= IDX_W'(DATA_IDX);
  assign in_released = idx_q >= IDX_W'(TA_IDX);
  assign last_fall   = tick_i && mdc_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      read_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      rd_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        mdc_q  <= 1'b0;
        read_q <= read_i;
        idx_q  <= '0;
        sh_q   <= frame_i;
      end
    end else if (tick_i) begin
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (read_q && in_data) rd_q <= {rd_q[14:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          sh_q   <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = last_fall;
  assign mdc_o     = mdc_q;
  assign mdio_o    = sh_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q && !(read_q && in_released);
  assign rd_data_o = rd_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  mdio_cmd_t             wcmd;
  logic [29:0]           cmd_q;
  logic                  busy, done, tick, start, wr_read;
  logic [FRAME_BITS-1:0] frame;
  logic [15:0]           rd_data;
  logic                  last_read_q;

  assign wcmd    = mdio_cmd_t'(reg_wdata_i);
  assign start   = reg_we_i && wcmd.go && !busy;
  assign wr_read = op_is_read(wcmd.op);
  // TA value is irrelevant on reads: the pin is released there
  assign frame   = {32'hFFFF_FFFF, wcmd.st, wcmd.op, wcmd.phyad, wcmd.regad,
                    2'b10, wcmd.data};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= '0;
      last_read_q <= 1'b0;
    end else if (start) begin
      cmd_q       <= reg_wdata_i[29:0];
      last_read_q <= wr_read;
    end else if (done && last_read_q) begin
      cmd_q[15:0] <= rd_data;
    end
  end

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .tick_o (tick)
  );

  mdio_frame_engine u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .frame_i   (frame),
    .read_i    (wr_read),
    .tick_i    (tick),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_data_o (rd_data)
  );

  assign reg_rdata_o = {busy, 1'b0, cmd_q};
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  a_r1_go_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[31] && reg_we_i && reg_wdata_i[31]) |=> reg_rdata_o[31]);

  a_r5_idle_mdc_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[31] |-> !mdc_o);

  a_r8_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[31] |-> !mdio_oe_o);

  a_r6_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31] && reg_we_i) |=> $stable(reg_rdata_o[29:16]));

  a_r10_nogo_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[31] && reg_we_i && !reg_wdata_i[31]) |=>
      (!reg_rdata_o[31] && $stable(reg_rdata_o)));

  a_r7_data_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31] && $past(reg_rdata_o[31]) && !$stable(mdio_o)) |-> $fell(mdc_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int HALF = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // scoreboard queues
  logic [63:0] exp_line_q[$];
  logic [63:0] exp_oe_q[$];
  string       exp_tag_q[$];

  // PHY model state
  logic        phy_read = 1'b0;
  logic [15:0] phy_data = '0;
  int          bit_cnt = 0;

  always #2.5 clk_i = ~clk_i;

  mdio_master #(.HALF_DIV(HALF)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  always_comb begin
    if (mdio_oe_o)                        mdio_i = mdio_o;
    else if (phy_read && bit_cnt == 47)   mdio_i = 1'b0;
    else if (phy_read && bit_cnt >= 48 && bit_cnt <= 63)
      mdio_i = phy_data[63-bit_cnt];
    else                                  mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  // monitor: captures line and enable at each MDC rise, checks timing
  logic [63:0] cap_line = '0, cap_oe = '0;
  logic prev_mdc = 1'b0, prev_busy = 1'b0, prev_oe = 1'b0, prev_mdo = 1'b0;
  bit   bad_period = 0, bad_phase = 0;
  int   hcyc = 0;

  always @(negedge clk_i) begin
    if (reg_rdata_o[31] && !prev_busy) begin
      hcyc = 0; bad_period = 0; bad_phase = 0;
    end else if (reg_rdata_o[31]) begin
      hcyc++;
      if (mdc_o != prev_mdc) begin
        if (hcyc != HALF) bad_period = 1;
        hcyc = 0;
      end
    end
    if (mdio_oe_o && prev_oe && mdio_o != prev_mdo && mdc_o) bad_phase = 1;
    if (mdc_o && !prev_mdc) begin
      cap_line = {cap_line[62:0], mdio_i};
      cap_oe   = {cap_oe[62:0], mdio_oe_o};
      bit_cnt++;
      if (bit_cnt == 64) begin
        bit_cnt = 0;
        if (exp_line_q.size() == 0) begin
          check(0, "R6 unexpected frame", cap_line, 64'h0);
        end else begin
          logic [63:0] el, eo;
          string tg;
          el = exp_line_q.pop_front();
          eo = exp_oe_q.pop_front();
          tg = exp_tag_q.pop_front();
          check(cap_line == el, {tg, " line"}, cap_line, el);
          check(cap_oe == eo, {tg, " oe"}, cap_oe, eo);
          check(!bad_period, "R7 half period", 64'(bad_period), 64'(0));
          check(!bad_phase, "R7 data change phase", 64'(bad_phase), 64'(0));
        end
      end
    end
    prev_mdc  = mdc_o;
    prev_busy = reg_rdata_o[31];
    prev_oe   = mdio_oe_o;
    prev_mdo  = mdio_o;
  end

  task automatic bus_write(input logic [31:0] w);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = w;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] pa, input logic [4:0] ra,
                                     input logic [15:0] d);
    return {1'b1, 1'b0, ra, pa, op, st, d};
  endfunction

  // driver: push expectation, issue, check busy and completion timing
  task automatic issue(input logic [31:0] w, input logic [15:0] pd, input string tag);
    logic [63:0] el, eo;
    bit rd;
    int n;
    rd = w[19];
    if (rd) begin
      el = {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25], 2'b10, pd};
      eo = {46'h3FFF_FFFF_FFFF, 18'h0};
    end else begin
      el = {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25], 2'b10, w[15:0]};
      eo = '1;
    end
    exp_line_q.push_back(el);
    exp_oe_q.push_back(eo);
    exp_tag_q.push_back(tag);
    phy_read = rd;
    phy_data = pd;
    bus_write(w);
    check(reg_rdata_o[31] == 1'b1, "R1 busy after go", 64'(reg_rdata_o[31]), 64'(1));
    n = 0;
    while (reg_rdata_o[31]) begin
      @(negedge clk_i);
      n++;
    end
    check(n == 128*HALF, "R5 busy duration", 64'(n), 64'(128*HALF));
    check(!mdc_o && !mdio_oe_o, "R5 R8 idle pins", {62'h0, mdc_o, mdio_oe_o}, 64'h0);
    check(reg_rdata_o[29:16] == w[29:16] && !reg_rdata_o[30], "R9 fields readback",
          64'(reg_rdata_o[30:16]), 64'(w[29:16]));
    if (rd)
      check(reg_rdata_o[15:0] == pd, "R4 read data", 64'(reg_rdata_o[15:0]), 64'(pd));
    else
      check(reg_rdata_o[15:0] == w[15:0], "R9 write data kept",
            64'(reg_rdata_o[15:0]), 64'(w[15:0]));
    phy_read = 1'b0;
  endtask

  initial begin
    logic [31:0] wa, snap;
    repeat (3) @(negedge clk_i);
    check(reg_rdata_o == 32'h0 && !mdc_o && !mdio_oe_o, "R8 reset state",
          {reg_rdata_o, 30'h0, mdc_o, mdio_oe_o}, 64'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    issue(mk(2'b01, 2'd1, 5'h05, 5'h1A, 16'hA5C3), 16'h0, "R2 R3 c22 write");
    issue(mk(2'b01, 2'd2, 5'h11, 5'h03, 16'h0000), 16'h1234, "R2 R4 c22 read");
    issue(mk(2'b00, 2'd0, 5'h02, 5'h1E, 16'h8001), 16'h0, "R2 R3 c45 address");
    issue(mk(2'b00, 2'd1, 5'h02, 5'h1E, 16'hBEEF), 16'h0, "R3 c45 write");
    issue(mk(2'b00, 2'd0, 5'h1F, 5'h07, 16'h0020), 16'h0, "R3 c45 address 2");
    issue(mk(2'b00, 2'd3, 5'h1F, 5'h07, 16'h0000), 16'hC0DE, "R4 c45 read");
    issue(mk(2'b01, 2'd2, 5'h00, 5'h1F, 16'hFFFF), 16'h8001, "R4 c22 read edge");

    // R6: second command while busy must be dropped
    wa = mk(2'b01, 2'd1, 5'h0A, 5'h0C, 16'h3C3C);
    exp_line_q.push_back({32'hFFFF_FFFF, wa[17:16], wa[19:18], wa[24:20], wa[29:25],
                          2'b10, wa[15:0]});
    exp_oe_q.push_back('1);
    exp_tag_q.push_back("R6 frame in progress");
    bus_write(wa);
    repeat (10) @(negedge clk_i);
    bus_write(mk(2'b00, 2'd3, 5'h15, 5'h15, 16'h5555));
    check(reg_rdata_o[29:16] == wa[29:16], "R6 fields held", 64'(reg_rdata_o[29:16]),
          64'(wa[29:16]));
    while (reg_rdata_o[31]) @(negedge clk_i);
    repeat (8*HALF) @(negedge clk_i);
    check(!reg_rdata_o[31] && !mdc_o && bit_cnt == 0, "R6 no follow-on frame",
          {reg_rdata_o[31], mdc_o, 62'(bit_cnt)}, 64'h0);
    check(reg_rdata_o == {2'b00, wa[29:0]}, "R6 word after frame", 64'(reg_rdata_o),
          64'({2'b00, wa[29:0]}));

    // R10: write without go while idle
    snap = reg_rdata_o;
    bus_write({1'b0, 1'b0, 5'h13, 5'h13, 2'd1, 2'b01, 16'h7777});
    repeat (4*HALF) @(negedge clk_i);
    check(reg_rdata_o == snap && !mdc_o && bit_cnt == 0, "R10 no-go write ignored",
          64'(reg_rdata_o), 64'(snap));

    check(exp_line_q.size() == 0, "R2 all frames seen", 64'(exp_line_q.size()), 64'h0);
    finish_run();
  end
endmodule